// File: doc/BRIEF.md
# Deep Idle Power-Down Sequencer

This controller walks a processor core from normal execution into a power-off idle state that keeps the core's state, and then brings it back. A software idle request starts an ordered entry. The core shrinks its cache, saves its state to an always-on store, tells the platform it is going down, waits for the platform to stop the clock and fence I/O, and then turns the core regulator off. An interrupt that the platform forwards as a break event runs the reverse order: regulator ramp, bus clock restart, internal reset with PLL relock, state restore, cache re-expansion and resume. Each step is a request/acknowledge pair with the agent that does the work (microcode, memory, platform, regulator). A per-step watchdog stops the sequence if an acknowledge never arrives.

An interval tracker captures a free-running counter at every break event and keeps the last few gaps between interrupts. When that history is full and the mean gap is below a programmable threshold, a deep entry would cost more energy than it saves. The idle request is then demoted to a shallower state that needs no save or power-down. A break event during the early entry steps abandons the entry and goes straight to the restore path. A restore that reports an uncorrectable ECC error parks the sequencer in a fault state instead of resuming.

States and their `seq_state` codes: ACTIVE=0, SHRINK=1, SAVE=2, ENTER=3, CLKBLK=4, VROFF=5, DEEP=6, VRUP=7, BCLK=8, PLLRST=9, RESTORE=10, EXPAND=11, SHALLOW=12, FAULT=13. Transitions: ACTIVE→SHRINK (idle request, no demotion), ACTIVE→SHALLOW (idle request, demotion), each step→next step (acknowledge), SHRINK..CLKBLK→RESTORE (break abort), VROFF→DEEP, DEEP→VRUP (break, or break latched during VROFF), EXPAND→ACTIVE, SHALLOW→ACTIVE (break), any step→FAULT (timeout), RESTORE→FAULT (ECC error).

Top module: `deep_idle_seq`

## Requirements
- R1: After reset `seq_state` is 0 (ACTIVE), and `step_req`, `resume`, `fault_ecc`, `fault_tmo` and `snoop_held` are all low.
- R2: An idle request in ACTIVE that is not demoted steps through codes 1,2,3,4,5 in that order. Each step holds `step_req` high and moves on only on `step_ack`. After the acknowledge of code 5 the state is DEEP (6), with `step_req` low.
- R3: From DEEP a break event runs codes 7,8,9,10,11 in order, each on its acknowledge. The sequencer then returns to ACTIVE (0), with `resume` high for exactly one cycle.
- R4: While the state is CLKBLK, VROFF or DEEP (4, 5, 6), `snoop_held` follows `dma_snoop`. A DMA snoop never moves the state out of DEEP.
- R5: A break event while ACTIVE leaves the state at ACTIVE.
- R6: A break event during SHRINK, SAVE, ENTER or CLKBLK (1–4) moves the state to RESTORE (10) on the next edge, ahead of any acknowledge or timeout in that cycle. The run then ends via EXPAND (11) in ACTIVE with `resume`.
- R7: A break event during VROFF (5) is remembered. VROFF still completes to DEEP, and DEEP then leaves for VRUP (7) on the following edge without another break.
- R8: A step whose acknowledge has not arrived after STEP_TMO cycles in that step moves to FAULT (13) and sets `fault_tmo`.
- R9: An acknowledge in RESTORE with `ecc_err` high moves to FAULT and sets `fault_ecc`; `resume` does not pulse.
- R10: If the last HIST_N break-to-break intervals are all recorded and their mean is below `demote_thresh`, an idle request moves ACTIVE to SHALLOW (12). A break event in SHALLOW returns to ACTIVE with a one-cycle `resume`.
- R11: A mean interval equal to or above `demote_thresh`, or a history holding fewer than HIST_N intervals since reset, sends an idle request down the deep path (code 1).
- R12: FAULT is held with its flags until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Software idle request, one-cycle pulse |
| brk_evt | input | 1 | Interrupt break event forwarded by the platform |
| dma_snoop | input | 1 | DMA snoop presented by the platform |
| step_ack | input | 1 | Acknowledge for the step currently requested |
| ecc_err | input | 1 | Uncorrectable error flag returned with the restore acknowledge |
| demote_thresh | input | CNT_W | Mean-interval threshold in cycles below which idle is demoted |
| seq_state | output | 4 | Current sequencer state code |
| step_req | output | 1 | A step is being requested from its agent |
| snoop_held | output | 1 | Snoop is held off by the platform instead of waking the core |
| resume | output | 1 | One-cycle pulse on return to execution |
| fault_ecc | output | 1 | Sticky restore ECC failure |
| fault_tmo | output | 1 | Sticky step acknowledge timeout |

## Verification
Assertions check on every cycle the properties that concern one or two edges. DEEP is held unless a break is seen or pending. A pending break leaves DEEP on the next edge. FAULT is held once reached. `resume` and `fault_ecc` rise only after the right predecessor state. The step timer stays inside its window, and the interval history never overfills. Only the directed scenarios can show the full order of the entry and exit codes, an abort partway through entry, a break caught during regulator-down, the exact timeout cycle, and the demotion decision on either side of the threshold, because these depend on long stimulus histories and on the bench's mean-interval arithmetic.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    typedef enum logic [3:0] {
        ST_ACTIVE  = 4'd0,
        ST_SHRINK  = 4'd1,
        ST_SAVE    = 4'd2,
        ST_ENTER   = 4'd3,
        ST_CLKBLK  = 4'd4,
        ST_VROFF   = 4'd5,
        ST_DEEP    = 4'd6,
        ST_VRUP    = 4'd7,
        ST_BCLK    = 4'd8,
        ST_PLLRST  = 4'd9,
        ST_RESTORE = 4'd10,
        ST_EXPAND  = 4'd11,
        ST_SHALLOW = 4'd12,
        ST_FAULT   = 4'd13
    } pd_state_e;

endpackage

// File: rtl/pd_gap_tracker.sv
// Keeps the last HIST_N break-to-break intervals and flags a short mean.
module pd_gap_tracker #(
    parameter int CNT_W  = 24,
    parameter int HIST_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [CNT_W-1:0] thresh,
    output logic             short_gaps
);
    localparam int LGN   = $clog2(HIST_N);
    localparam int SUM_W = CNT_W + LGN;
    localparam int FIL_W = LGN + 1;

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] last_cap;
    logic [CNT_W-1:0] hist [HIST_N];
    logic [SUM_W-1:0] sum_q;
    logic [FIL_W-1:0] fill_q;
    logic [CNT_W-1:0] gap;
    logic [SUM_W-1:0] mean;

    assign gap  = free_cnt - last_cap;
    assign mean = sum_q >> LGN;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt <= '0;
            last_cap <= '0;
            sum_q    <= '0;
            fill_q   <= '0;
        end else begin
            free_cnt <= free_cnt + 1'b1;
            if (evt) begin
                last_cap <= free_cnt;
                sum_q    <= sum_q - SUM_W'(hist[HIST_N-1]) + SUM_W'(gap);
                if (fill_q != FIL_W'(HIST_N))
                    fill_q <= fill_q + 1'b1;
            end
        end
    end

    generate
        for (genvar i = 0; i < HIST_N; i++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist[i] <= '0;
                else if (evt)
                    hist[i] <= (i == 0) ? gap : hist[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign short_gaps = (fill_q == FIL_W'(HIST_N)) && (mean < SUM_W'(thresh));

    // R10
    hist_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FIL_W'(HIST_N));

endmodule

// File: rtl/pd_step_timer.sv
// Counts cycles spent in one requested step; expires after STEP_TMO cycles.
module pd_step_timer #(
    parameter int STEP_TMO = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adv,
    output logic expired
);
    localparam int TW = $clog2(STEP_TMO + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || adv)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == TW'(STEP_TMO - 1));

    // R8
    tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(STEP_TMO - 1));

endmodule

// File: rtl/deep_idle_seq.sv
module deep_idle_seq
    import pd_seq_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int HIST_N   = 8,
    parameter int STEP_TMO = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             brk_evt,
    input  logic             dma_snoop,
    input  logic             step_ack,
    input  logic             ecc_err,
    input  logic [CNT_W-1:0] demote_thresh,
    output logic [3:0]       seq_state,
    output logic             step_req,
    output logic             snoop_held,
    output logic             resume,
    output logic             fault_ecc,
    output logic             fault_tmo
);
    pd_state_e st_q, st_d;
    logic      short_gaps;
    logic      tmo_hit;
    logic      brk_pend;
    logic      adv;
    logic      in_fence;

    pd_gap_tracker #(.CNT_W(CNT_W), .HIST_N(HIST_N)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (brk_evt),
        .thresh     (demote_thresh),
        .short_gaps (short_gaps)
    );

    assign adv = (st_d != st_q);

    pd_step_timer #(.STEP_TMO(STEP_TMO)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (step_req),
        .adv     (adv),
        .expired (tmo_hit)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE:  if (idle_req) st_d = short_gaps ? ST_SHALLOW : ST_SHRINK;
            ST_SHRINK:  if (brk_evt) st_d = ST_RESTORE;
                        else if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_SAVE;
            ST_SAVE:    if (brk_evt) st_d = ST_RESTORE;
                        else if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_ENTER;
            ST_ENTER:   if (brk_evt) st_d = ST_RESTORE;
                        else if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_CLKBLK;
            ST_CLKBLK:  if (brk_evt) st_d = ST_RESTORE;
                        else if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_VROFF;
            ST_VROFF:   if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_DEEP;
            ST_DEEP:    if (brk_evt || brk_pend) st_d = ST_VRUP;
            ST_VRUP:    if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_BCLK;
            ST_BCLK:    if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_PLLRST;
            ST_PLLRST:  if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_RESTORE;
            ST_RESTORE: if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ecc_err ? ST_FAULT : ST_EXPAND;
            ST_EXPAND:  if (tmo_hit) st_d = ST_FAULT;
                        else if (step_ack) st_d = ST_ACTIVE;
            ST_SHALLOW: if (brk_evt) st_d = ST_ACTIVE;
            ST_FAULT:   st_d = ST_FAULT;
            default:    st_d = ST_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ACTIVE;
        else        st_q <= st_d;
    end

    // combinational outputs
    always_comb begin
        step_req = 1'b0;
        in_fence = 1'b0;
        unique case (st_q)
            ST_ACTIVE, ST_SHALLOW, ST_FAULT: ;
            ST_DEEP:                         in_fence = 1'b1;
            ST_CLKBLK, ST_VROFF: begin
                step_req = 1'b1;
                in_fence = 1'b1;
            end
            default:                         step_req = 1'b1;
        endcase
    end

    assign seq_state  = st_q;
    assign snoop_held = in_fence && dma_snoop;

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume    <= 1'b0;
            fault_ecc <= 1'b0;
            fault_tmo <= 1'b0;
            brk_pend  <= 1'b0;
        end else begin
            resume <= (st_d == ST_ACTIVE) &&
                      ((st_q == ST_EXPAND) || (st_q == ST_SHALLOW));
            if (st_q == ST_RESTORE && step_ack && ecc_err && !tmo_hit)
                fault_ecc <= 1'b1;
            if (tmo_hit)
                fault_tmo <= 1'b1;
            if (st_q == ST_VROFF && brk_evt)
                brk_pend <= 1'b1;
            else if (st_q == ST_DEEP)
                brk_pend <= 1'b0;
        end
    end

    // R4
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEEP && !brk_evt && !brk_pend) |=> st_q == ST_DEEP);

    // R7
    pend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEEP && brk_pend) |=> st_q == ST_VRUP);

    // R12
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_FAULT |=> (st_q == ST_FAULT && $stable(fault_ecc) && $stable(fault_tmo)));

    // R3
    resume_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume) |-> ($past(st_q) == ST_EXPAND || $past(st_q) == ST_SHALLOW));

    // R9
    ecc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_ecc) |-> ($past(st_q) == ST_RESTORE && $past(ecc_err)));

    // R2
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_DEEP) ##1 (st_q == ST_DEEP) |-> $past(st_q) == ST_VROFF);

endmodule

// File: tb/test_deep_idle_seq.sv
module test_deep_idle_seq;
    localparam int CNT_W = 16;
    localparam int HN    = 4;
    localparam int TMO   = 32;
    localparam int ACK_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 1'b0, brk_evt = 1'b0, dma_snoop = 1'b0;
    logic step_ack = 1'b0, ecc_err = 1'b0;
    logic [CNT_W-1:0] demote_thresh = 16'd100;
    logic [3:0] seq_state;
    logic step_req, snoop_held, resume, fault_ecc, fault_tmo;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit auto_ack = 1'b1, ecc_inject = 1'b0;
    int dly = 0;
    int log_q [64];
    int log_n = 0;
    int resume_n = 0;

    always #4 clk = ~clk;

    deep_idle_seq #(.CNT_W(CNT_W), .HIST_N(HN), .STEP_TMO(TMO)) i_deep_idle_seq (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .brk_evt(brk_evt),
        .dma_snoop(dma_snoop), .step_ack(step_ack), .ecc_err(ecc_err),
        .demote_thresh(demote_thresh), .seq_state(seq_state), .step_req(step_req),
        .snoop_held(snoop_held), .resume(resume), .fault_ecc(fault_ecc), .fault_tmo(fault_tmo));

    // acknowledge responder and monitors
    always @(negedge clk) begin
        cyc++;
        if (resume) resume_n++;
        if (step_ack) begin
            step_ack = 1'b0;
            ecc_err  = 1'b0;
            dly = 0;
        end else if (auto_ack && step_req) begin
            if (dly == ACK_LAT) begin
                step_ack = 1'b1;
                ecc_err  = ecc_inject && (seq_state == 4'd10);
                if (log_n < 64) log_q[log_n] = seq_state;
                log_n++;
                dly = 0;
            end else dly++;
        end else dly = 0;
        if (cyc > 150000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle_req = 0; brk_evt = 0; dma_snoop = 0;
        auto_ack = 1; ecc_inject = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        log_n = 0; resume_n = 0;
    endtask

    task automatic pulse_idle();
        idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
    endtask

    task automatic pulse_brk();
        brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
    endtask

    task automatic wait_state(input int code, input int lim, output bit hit);
        hit = 0;
        for (int i = 0; i < lim; i++) begin
            if (seq_state == 4'(code)) begin hit = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic train(input int gap);
        for (int i = 0; i < HN + 1; i++) begin
            pulse_brk();
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        // R1
        chk(seq_state == 0, "R1 state", seq_state, 0);
        chk({step_req, resume, fault_ecc, fault_tmo, snoop_held} == 5'b0, "R1 outputs",
            {step_req, resume, fault_ecc, fault_tmo, snoop_held}, 0);
    endtask

    task automatic t_full_cycle();
        bit hit;
        bit ok;
        do_reset();
        pulse_idle();
        wait_state(6, 200, hit);
        // R2
        chk(hit, "R2 reach DEEP", seq_state, 6);
        ok = (log_n == 5);
        for (int i = 0; i < 5; i++) if (log_q[i] != i + 1) ok = 0;
        chk(ok, "R2 entry order", log_n, 5);
        chk(step_req == 0, "R2 no request in DEEP", step_req, 0);
        // R4
        dma_snoop = 1'b1;
        @(negedge clk);
        chk(snoop_held == 1, "R4 snoop held", snoop_held, 1);
        repeat (20) @(negedge clk);
        chk(seq_state == 6, "R4 snoop no wake", seq_state, 6);
        dma_snoop = 1'b0;
        log_n = 0; resume_n = 0;
        // R3
        pulse_brk();
        wait_state(0, 200, hit);
        chk(hit, "R3 back to ACTIVE", seq_state, 0);
        ok = (log_n == 5);
        for (int i = 0; i < 5; i++) if (log_q[i] != i + 7) ok = 0;
        chk(ok, "R3 exit order", log_n, 5);
        repeat (3) @(negedge clk);
        chk(resume_n == 1, "R3 single resume", resume_n, 1);
    endtask

    task automatic t_active_brk();
        do_reset();
        pulse_brk();
        repeat (2) @(negedge clk);
        // R5
        chk(seq_state == 0 && step_req == 0, "R5 break in ACTIVE", seq_state, 0);
    endtask

    task automatic t_abort();
        bit hit;
        do_reset();
        pulse_idle();
        wait_state(2, 100, hit);
        log_n = 0; resume_n = 0;
        pulse_brk();
        // R6
        chk(seq_state == 10, "R6 abort to RESTORE", seq_state, 10);
        wait_state(0, 100, hit);
        chk(hit && log_n == 2 && log_q[0] == 10 && log_q[1] == 11, "R6 abort path",
            log_n, 2);
        repeat (2) @(negedge clk);
        chk(resume_n == 1, "R6 resume after abort", resume_n, 1);
    endtask

    task automatic t_late_brk();
        bit hit;
        bit ok;
        do_reset();
        pulse_idle();
        wait_state(5, 100, hit);
        log_n = 0;
        pulse_brk();
        // R7
        chk(seq_state == 5, "R7 VROFF continues", seq_state, 5);
        wait_state(0, 200, hit);
        ok = hit && (log_n == 6) && (log_q[0] == 5);
        for (int i = 1; i < 6; i++) if (log_q[i] != i + 6) ok = 0;
        chk(ok, "R7 latched break exit", log_n, 6);
    endtask

    task automatic t_timeout();
        do_reset();
        auto_ack = 0;
        pulse_idle();
        chk(seq_state == 1, "R8 in SHRINK", seq_state, 1);
        repeat (TMO - 1) @(negedge clk);
        // R8
        chk(seq_state == 1 && !fault_tmo, "R8 not yet expired", seq_state, 1);
        @(negedge clk);
        chk(seq_state == 13 && fault_tmo, "R8 timeout fault", seq_state, 13);
        // R12
        auto_ack = 1;
        pulse_brk();
        pulse_idle();
        repeat (5) @(negedge clk);
        chk(seq_state == 13 && fault_tmo && !fault_ecc, "R12 fault held", seq_state, 13);
    endtask

    task automatic t_ecc();
        bit hit;
        do_reset();
        ecc_inject = 1;
        pulse_idle();
        wait_state(6, 200, hit);
        resume_n = 0;
        pulse_brk();
        wait_state(13, 200, hit);
        // R9
        chk(hit && fault_ecc && !fault_tmo, "R9 ECC fault", seq_state, 13);
        repeat (5) @(negedge clk);
        chk(resume_n == 0, "R9 no resume", resume_n, 0);
    endtask

    task automatic t_demote();
        bit hit;
        do_reset();
        train(50);
        resume_n = 0;
        pulse_idle();
        // R10
        chk(seq_state == 12, "R10 demote to SHALLOW", seq_state, 12);
        repeat (5) @(negedge clk);
        chk(seq_state == 12 && step_req == 0, "R10 SHALLOW held", seq_state, 12);
        pulse_brk();
        chk(seq_state == 0, "R10 SHALLOW exit", seq_state, 0);
        @(negedge clk);
        chk(resume_n == 1, "R10 resume", resume_n, 1);
    endtask

    task automatic t_no_demote();
        do_reset();
        train(100);
        pulse_idle();
        // R11
        chk(seq_state == 1, "R11 mean equal threshold", seq_state, 1);
        do_reset();
        for (int i = 0; i < HN - 1; i++) begin
            pulse_brk();
            repeat (9) @(negedge clk);
        end
        pulse_idle();
        chk(seq_state == 1, "R11 history not full", seq_state, 1);
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_active_brk();
        t_abort();
        t_late_brk();
        t_timeout();
        t_ecc();
        t_demote();
        t_no_demote();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule